// File: doc/BRIEF.md
# Ethernet MAC Control Register Bank

This block holds the software-visible control and status words of an Ethernet MAC behind a small word-addressed bus. A request carries a valid strobe, a write flag, a word address, four byte enables and 32 bits of write data. One cycle later the block returns a response: a valid pulse, an error flag and the read data. Each register has its own write behaviour. Some words are plain storage. Some are write-one-to-clear under a fixed mask. Two status words cannot be written at all. The mode word clears completion flags when an enable bit is switched on, and the counter-control word sends a one-cycle clear strobe to the statistics counters.

The MAC datapath sets status bits through one set-pulse input per status word. The mode word, the system control word and both status words go back to the datapath as plain outputs. The response path is a three-state machine with the states RS_IDLE, RS_OK and RS_ERR. A valid request that decodes moves the machine to RS_OK. A valid request that does not decode moves it to RS_ERR. A cycle with no request returns it to RS_IDLE. Each state can reach every other state, so back-to-back requests give one response per cycle. Word map: 0 mode, 1-2 station address low/high, 3-4 hash low/high, 5-6 VLAN tags A/B, 7 flow control, 8 wakeup control, 9-16 wakeup filter words, 17 system control, 18 system status, 19 RX status, 20 RX sticky, 21 RX interrupt enable, 22 TX status, 23 TX sticky, 24 TX interrupt enable, 25 counter control, 26 counter RX interrupt status, 27 its enable, 28 counter TX interrupt status, 29 its enable. Words 30 and above are unmapped.

Top module: `macreg_bank`

## Requirements
- R1: After reset, station address low reads 0xFFFFFFFF, station address high reads 0x0000FFFF, both VLAN tag words read 0x0000FFFF, system control reads 0x00003F00 and counter control reads 0x0000000A. Every other word reads 0.
- R2: The plain words store all 32 written bits and read them back unchanged. These are the mode, station address, hash, VLAN, flow control, wakeup filter, system control and the four interrupt-enable words.
- R3: A write to system status (word 18) clears each bit that is written as 1 and lies in mask 0xE1. All other bits keep their value.
- R4: A write to wakeup control (word 8) clears each bit in mask 0xF20 that is written as 1. The bits outside that mask take the written value.
- R5: Writes to RX status (word 19) and TX status (word 22) change nothing, but the write still gets a normal response.
- R6: The RX sticky, TX sticky and both counter interrupt-status words (20, 23, 26, 28) are write-one-to-clear on all 32 bits.
- R7: In the mode word, bit 0 is receive enable and bit 1 is transmit enable. A mode write that takes bit 0 from 0 to 1 clears bit 0 of RX status, which is the receive completion flag. A mode write that takes bit 1 from 0 to 1 clears bit 0 of TX status, which is the transmit completion flag. A write that leaves an enable bit at 1 clears nothing.
- R8: Writing counter control (word 25) with bit 0 set raises cnt_clear_o for exactly the one cycle in which the response is valid. Bit 0 always reads back as 0, and the other bits are stored.
- R9: A request with byte enables other than 4'hF, or with a word address of 30 or above, gets rsp_err with zero read data and changes no register.
- R10: Every accepted request gets rsp_valid in the following cycle, with no gaps between back-to-back requests. Write responses carry zero read data.
- R11: When a set-pulse input raises a status bit in the same cycle that a software write or an enable edge would clear it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| mode_o | output | 32 | Mode word to the MAC |
| sysctl_o | output | 32 | System control word to the MAC |
| rx_status_o | output | 32 | RX status word |
| tx_status_o | output | 32 | TX status word |
| cnt_clear_o | output | 1 | One-cycle clear strobe for all statistics counters |
| set_sys_i | input | 32 | Set pulses for system status |
| set_wake_i | input | 32 | Set pulses for wakeup control |
| set_rxst_i | input | 32 | Set pulses for RX status |
| set_rxsk_i | input | 32 | Set pulses for RX sticky |
| set_txst_i | input | 32 | Set pulses for TX status |
| set_txsk_i | input | 32 | Set pulses for TX sticky |
| set_crx_i | input | 32 | Set pulses for counter RX interrupt status |
| set_ctx_i | input | 32 | Set pulses for counter TX interrupt status |

## Verification
A wrong clear mask or a wrong write kind on any word shows up in the very next read of that word, two cycles after the faulty write. A stuck response state appears within one cycle as a missing, extra or error-flagged rsp_valid pulse. A broken enable-edge detector shows on rx_status_o or tx_status_o in the cycle after the mode write. A faulty counter-control path shows as a missing or repeated cnt_clear_o pulse in the response cycle of that write.

// File: rtl/macreg_pkg.sv
package macreg_pkg;

    localparam int DW   = 32;
    localparam int NREG = 30;

    localparam int OFF_MODE     = 0;
    localparam int OFF_ADDR_LO  = 1;
    localparam int OFF_ADDR_HI  = 2;
    localparam int OFF_VLAN_A   = 5;
    localparam int OFF_VLAN_B   = 6;
    localparam int OFF_WAKE     = 8;
    localparam int OFF_SYS_CTL  = 17;
    localparam int OFF_SYS_STAT = 18;
    localparam int OFF_RX_STAT  = 19;
    localparam int OFF_RX_STKY  = 20;
    localparam int OFF_TX_STAT  = 22;
    localparam int OFF_TX_STKY  = 23;
    localparam int OFF_CNT_CTL  = 25;
    localparam int OFF_CNT_RIRQ = 26;
    localparam int OFF_CNT_TIRQ = 28;

    localparam int MODE_RXEN = 0;
    localparam int MODE_TXEN = 1;
    localparam int DONE_BIT  = 0;

    typedef enum logic [2:0] {
        RK_RW,
        RK_W1C,
        RK_W1P,
        RK_RO,
        RK_CNT
    } rkind_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_OK,
        RS_ERR
    } rstate_t;

    function automatic rkind_t reg_kind(input int i);
        case (i)
            OFF_SYS_STAT, OFF_RX_STKY, OFF_TX_STKY,
            OFF_CNT_RIRQ, OFF_CNT_TIRQ: return RK_W1C;
            OFF_WAKE:                   return RK_W1P;
            OFF_RX_STAT, OFF_TX_STAT:   return RK_RO;
            OFF_CNT_CTL:                return RK_CNT;
            default:                    return RK_RW;
        endcase
    endfunction

    function automatic logic [DW-1:0] reg_rst(input int i);
        case (i)
            OFF_ADDR_LO:            return 32'hFFFF_FFFF;
            OFF_ADDR_HI:            return 32'h0000_FFFF;
            OFF_VLAN_A, OFF_VLAN_B: return 32'h0000_FFFF;
            OFF_SYS_CTL:            return 32'h0000_3F00;
            OFF_CNT_CTL:            return 32'h0000_000A;
            default:                return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] reg_mask(input int i);
        case (i)
            OFF_SYS_STAT: return 32'h0000_00E1;
            OFF_WAKE:     return 32'h0000_0F20;
            default:      return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/macreg_cell.sv
module macreg_cell
    import macreg_pkg::*;
#(
    parameter rkind_t        KIND = RK_RW,
    parameter logic [DW-1:0] RSTV = '0,
    parameter logic [DW-1:0] MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] hw_clr,
    input  logic [DW-1:0] hw_set,
    output logic [DW-1:0] q
);
    logic [DW-1:0] nxt;

    always_comb begin
        nxt = q;
        if (we) begin
            case (KIND)
                RK_RW:   nxt = wdata;
                RK_W1C:  nxt = q & ~(wdata & MASK);
                RK_W1P:  nxt = (wdata & ~MASK) | (q & MASK & ~wdata);
                RK_CNT:  nxt = wdata & ~{{(DW-1){1'b0}}, 1'b1};
                default: nxt = q;
            endcase
        end
        // datapath set pulses win over any clear in the same cycle
        nxt = (nxt & ~hw_clr) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RSTV;
        else        q <= nxt;
    end
endmodule

// File: rtl/macreg_decode.sv
module macreg_decode
    import macreg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    output logic [NREG-1:0]   hit,
    output logic              bad
);
    logic ok;

    assign ok  = (req_be == 4'hF) && (req_addr < ADDR_W'(NREG));
    assign bad = req_valid && !ok;

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = req_valid && ok && (req_addr == ADDR_W'(i));
    end
endmodule

// File: rtl/macreg_resp.sv
module macreg_resp
    import macreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_bad,
    input  logic [DW-1:0] rd_val,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata
);
    rstate_t state, state_nxt;

    always_comb begin
        unique case (state)
            RS_IDLE, RS_OK, RS_ERR: begin
                if (!req_valid)   state_nxt = RS_IDLE;
                else if (req_bad) state_nxt = RS_ERR;
                else              state_nxt = RS_OK;
            end
            default: state_nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RS_IDLE;
            rsp_rdata <= '0;
        end else begin
            state     <= state_nxt;
            rsp_rdata <= (req_valid && !req_write && !req_bad) ? rd_val : '0;
        end
    end

    always_comb begin
        unique case (state)
            RS_OK:   begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            RS_ERR:  begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default: begin rsp_valid = 1'b0; rsp_err = 1'b0; end
        endcase
    end
endmodule

// File: rtl/macreg_bank.sv
module macreg_bank
    import macreg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic [31:0]       mode_o,
    output logic [31:0]       sysctl_o,
    output logic [31:0]       rx_status_o,
    output logic [31:0]       tx_status_o,
    output logic              cnt_clear_o,
    input  logic [31:0]       set_sys_i,
    input  logic [31:0]       set_wake_i,
    input  logic [31:0]       set_rxst_i,
    input  logic [31:0]       set_rxsk_i,
    input  logic [31:0]       set_txst_i,
    input  logic [31:0]       set_txsk_i,
    input  logic [31:0]       set_crx_i,
    input  logic [31:0]       set_ctx_i
);
    logic [NREG-1:0] hit;
    logic            req_bad;
    logic [NREG-1:0] we;
    logic [DW-1:0]   q_all   [NREG];
    logic [DW-1:0]   set_all [NREG];
    logic [DW-1:0]   clr_all [NREG];
    logic [DW-1:0]   rd_val;
    logic            rx_rise, tx_rise;

    macreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .hit       (hit),
        .bad       (req_bad)
    );

    assign we = hit & {NREG{req_write}};

    assign rx_rise = we[OFF_MODE] && req_wdata[MODE_RXEN] && !q_all[OFF_MODE][MODE_RXEN];
    assign tx_rise = we[OFF_MODE] && req_wdata[MODE_TXEN] && !q_all[OFF_MODE][MODE_TXEN];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            set_all[i] = '0;
            clr_all[i] = '0;
        end
        set_all[OFF_SYS_STAT] = set_sys_i;
        set_all[OFF_WAKE]     = set_wake_i;
        set_all[OFF_RX_STAT]  = set_rxst_i;
        set_all[OFF_RX_STKY]  = set_rxsk_i;
        set_all[OFF_TX_STAT]  = set_txst_i;
        set_all[OFF_TX_STKY]  = set_txsk_i;
        set_all[OFF_CNT_RIRQ] = set_crx_i;
        set_all[OFF_CNT_TIRQ] = set_ctx_i;
        clr_all[OFF_RX_STAT][DONE_BIT] = rx_rise;
        clr_all[OFF_TX_STAT][DONE_BIT] = tx_rise;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        macreg_cell #(
            .KIND (reg_kind(i)),
            .RSTV (reg_rst(i)),
            .MASK (reg_mask(i))
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (we[i]),
            .wdata  (req_wdata),
            .hw_clr (clr_all[i]),
            .hw_set (set_all[i]),
            .q      (q_all[i])
        );
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) rd_val = rd_val | q_all[i];
    end

    macreg_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_bad   (req_bad),
        .rd_val    (rd_val),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_clear_o <= 1'b0;
        else        cnt_clear_o <= we[OFF_CNT_CTL] && req_wdata[0];
    end

    assign mode_o      = q_all[OFF_MODE];
    assign sysctl_o    = q_all[OFF_SYS_CTL];
    assign rx_status_o = q_all[OFF_RX_STAT];
    assign tx_status_o = q_all[OFF_TX_STAT];
endmodule

// File: rtl/macreg_bank_chk.sv
module macreg_bank_chk
    import macreg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_be,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       mode_o,
    input logic [31:0]       sysctl_o,
    input logic [31:0]       rx_status_o,
    input logic [31:0]       tx_status_o,
    input logic              cnt_clear_o,
    input logic [31:0]       set_rxst_i,
    input logic [31:0]       set_txst_i
);
    logic good_wr, bad_req;
    assign good_wr = req_valid && req_write && (req_be == 4'hF);
    assign bad_req = req_valid && ((req_be != 4'hF) || (req_addr >= ADDR_W'(NREG)));

    assert_resp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_bad_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> (rsp_err && $stable(mode_o) && $stable(sysctl_o)));

    assert_rx_stat_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && req_addr == ADDR_W'(OFF_RX_STAT) && set_rxst_i == '0) |=> $stable(rx_status_o));

    assert_rx_edge_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && req_addr == ADDR_W'(OFF_MODE) && req_wdata[MODE_RXEN]
         && !mode_o[MODE_RXEN] && !set_rxst_i[DONE_BIT]) |=> !rx_status_o[DONE_BIT]);

    assert_tx_edge_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && req_addr == ADDR_W'(OFF_MODE) && req_wdata[MODE_TXEN]
         && !mode_o[MODE_TXEN] && !set_txst_i[DONE_BIT]) |=> !tx_status_o[DONE_BIT]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_rxst_i[DONE_BIT] |=> rx_status_o[DONE_BIT]);

    assert_clear_strobe_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear_o |-> $past(good_wr && req_addr == ADDR_W'(OFF_CNT_CTL) && req_wdata[0]));

    assert_clear_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear_o |=> !cnt_clear_o || $past(good_wr && req_addr == ADDR_W'(OFF_CNT_CTL)));
endmodule

bind macreg_bank macreg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/macreg_bank_bench.sv
`timescale 1ns/1ps
module macreg_bank_bench;
    localparam int  AW  = 6;
    localparam time CLK = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err, cnt_clear_o;
    logic [31:0]   rsp_rdata, mode_o, sysctl_o, rx_status_o, tx_status_o;
    logic [31:0]   set_sys_i = '0, set_wake_i = '0, set_rxst_i = '0, set_rxsk_i = '0;
    logic [31:0]   set_txst_i = '0, set_txsk_i = '0, set_crx_i = '0, set_ctx_i = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic        err;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK/2) clk = ~clk;

    macreg_bank #(.ADDR_W(AW)) u_macreg_bank (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop one expected item per response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check("R10 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
                check({e.tag, " data"}, rsp_rdata, e.data);
            end
        end
    end

    task automatic access(input logic wr, input int a, input logic [3:0] be,
                          input logic [31:0] wd, input logic eerr,
                          input logic [31:0] edata, input string tag);
        exp_t e;
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a);
        req_be = be; req_wdata = wd;
        e.err = eerr; e.data = edata; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        access(1'b1, a, 4'hF, d, 1'b0, 32'h0, tag);
    endtask

    task automatic rd(input int a, input logic [31:0] d, input string tag);
        access(1'b0, a, 4'hF, 32'h0, 1'b0, d, tag);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic clear_sets();
        set_sys_i = '0; set_wake_i = '0; set_rxst_i = '0; set_rxsk_i = '0;
        set_txst_i = '0; set_txsk_i = '0; set_crx_i = '0; set_ctx_i = '0;
    endtask

    initial begin
        #(CLK * 100000);
        if (!done) begin
            check("watchdog expired", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset values
        check("R1 mode_o", mode_o, 32'h0);
        check("R1 sysctl_o", sysctl_o, 32'h0000_3F00);
        check("R1 cnt_clear_o", {31'd0, cnt_clear_o}, 32'd0);
        check("R10 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rd(1,  32'hFFFF_FFFF, "R1 addr lo");
        rd(2,  32'h0000_FFFF, "R1 addr hi");
        rd(5,  32'h0000_FFFF, "R1 vlan a");
        rd(6,  32'h0000_FFFF, "R1 vlan b");
        rd(17, 32'h0000_3F00, "R1 sysctl");
        rd(25, 32'h0000_000A, "R1 cnt ctl");
        rd(3,  32'h0,         "R1 hash lo");
        rd(18, 32'h0,         "R1 sys stat");

        // R2 plain storage, back-to-back (R10)
        wr(3,  32'hA5A5_1234, "R2 wr hash");
        wr(7,  32'h0F0F_F0F0, "R2 wr flow");
        wr(12, 32'hDEAD_BEEF, "R2 wr filter");
        rd(3,  32'hA5A5_1234, "R2 hash");
        rd(7,  32'h0F0F_F0F0, "R2 flow");
        rd(12, 32'hDEAD_BEEF, "R2 filter");

        // R3 system status masked clear
        set_sys_i = 32'hFFFF_FFFF; tick(); clear_sets();
        wr(18, 32'hFFFF_FFFF, "R3 wr ones");
        rd(18, 32'hFFFF_FF1E, "R3 masked clear");
        wr(18, 32'h0, "R3 wr zero");
        rd(18, 32'hFFFF_FF1E, "R3 zero write keeps");

        // R4 wakeup control partial clear
        wr(8, 32'h0000_0F0F, "R4 wr");
        rd(8, 32'h0000_000F, "R4 plain bits");
        set_wake_i = 32'h0000_0FFF; tick(); clear_sets();
        wr(8, 32'h0000_0120, "R4 wr clear");
        rd(8, 32'h0000_0E00, "R4 masked clear");

        // R5 status words ignore writes
        set_rxst_i = 32'h55; set_txst_i = 32'h3; tick(); clear_sets();
        wr(19, 32'hFFFF_FFFF, "R5 wr rx stat");
        wr(22, 32'h0, "R5 wr tx stat");
        rd(19, 32'h55, "R5 rx stat");
        rd(22, 32'h3, "R5 tx stat");
        check("R5 rx_status_o", rx_status_o, 32'h55);

        // R6 full-width write-one-to-clear
        set_rxsk_i = 32'hF0F0_00FF; set_crx_i = 32'hFFFF_FFFF; tick(); clear_sets();
        wr(20, 32'h0000_000F, "R6 wr rx sticky");
        wr(26, 32'hFFFF_FFFF, "R6 wr cnt rirq");
        rd(20, 32'hF0F0_00F0, "R6 rx sticky");
        rd(26, 32'h0, "R6 cnt rirq");

        // R7 enable edge clears completion flag
        wr(0, 32'h1, "R7 rx enable");
        check("R7 rx done cleared", rx_status_o, 32'h54);
        set_rxst_i = 32'h1; tick(); clear_sets();
        wr(0, 32'h1, "R7 rx enable held");
        check("R7 no clear when held", rx_status_o, 32'h55);
        wr(0, 32'h3, "R7 tx enable");
        check("R7 tx done cleared", tx_status_o, 32'h2);
        check("R7 rx untouched", rx_status_o, 32'h55);

        // R11 set beats edge clear
        wr(0, 32'h0, "R11 disable");
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(0);
        req_be = 4'hF; req_wdata = 32'h1; set_rxst_i = 32'h1;
        begin
            exp_t e;
            e.err = 1'b0; e.data = 32'h0; e.tag = "R11 wr";
            sb.push_back(e);
        end
        tick(); req_valid = 1'b0; clear_sets();
        check("R11 set wins", rx_status_o, 32'h55);

        // R8 counter clear strobe
        wr(25, 32'hFFFF_FFFF, "R8 wr clear");
        check("R8 strobe high", {31'd0, cnt_clear_o}, 32'd1);
        tick();
        check("R8 strobe one cycle", {31'd0, cnt_clear_o}, 32'd0);
        rd(25, 32'hFFFF_FFFE, "R8 bit0 reads 0");
        wr(25, 32'h4, "R8 wr no clear");
        check("R8 no strobe", {31'd0, cnt_clear_o}, 32'd0);
        rd(25, 32'h4, "R8 stored");

        // R9 errors
        access(1'b1, 3, 4'h3, 32'h1111_1111, 1'b1, 32'h0, "R9 partial write");
        rd(3, 32'hA5A5_1234, "R9 unchanged");
        access(1'b0, 40, 4'hF, 32'h0, 1'b1, 32'h0, "R9 unmapped read");
        access(1'b1, 63, 4'hF, 32'hFFFF_FFFF, 1'b1, 32'h0, "R9 unmapped write");
        access(1'b0, 17, 4'h1, 32'h0, 1'b1, 32'h0, "R9 partial read");
        rd(17, 32'h0000_3F00, "R9 sysctl kept");

        tick(); tick();
        check("R10 all responses seen", sb.size(), 32'd0);
        check("R10 idle after drain", {31'd0, rsp_valid}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule